// File: doc/BRIEF.md
# Chip-erase and program-suspend command interpreter

This block is the device-side command front end of a parallel NOR flash. It watches synchronous host write cycles (address, data, write strobe), recognises the multi-write unlock sequences for chip erase and word program, and then runs the resulting embedded operation by itself. A cycle counter stands in for the embedded algorithms. A chip erase first passes through a preprogram-and-verify phase and then an erase phase. A program may be paused with a single suspend write and continued with a single resume write.

The host follows progress in two ways. A mode output names the current operation. A status byte behaves like the polling bits of such parts: a toggle bit flips on every status read while work is in progress, a second toggle bit flips only during erase, and a data-polling bit shows the complement of the expected final bit until the operation ends. The synchronous active-low reset doubles as the hardware reset pin, and it aborts a chip erase at once.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, mode reads 0 (read mode) and status reads 80h.
- R2: In read mode, the six writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h, each address matched in full, start a chip erase: mode reads 4 in the cycle after the last write.
- R3: A write whose address or data does not match the expected step returns the decoder to its idle state, so the rest of the broken sequence starts nothing and mode stays 0.
- R4: A chip erase keeps mode 4 (preprogram/verify) for PREP_CYCLES cycles, then mode 5 (erase) for ERASE_CYCLES cycles, then returns to mode 0.
- R5: While mode is 4 or 5, every write is ignored, suspend (B0h) and complete command sequences included, and both erase phases keep their full lengths.
- R6: Driving rst_n low during a chip erase returns mode to 0 at the next clock edge.
- R7: In read mode, 555h/AAh, 2AAh/55h, 555h/A0h followed by one write of the program data start a program: mode 1 for PROG_CYCLES cycles in total, then mode 0.
- R8: A write of data B0h at any address while mode is 1 suspends the program: mode 2 for SUSP_CYCLES cycles, then mode 3. The program cycles already spent are kept, so the time spent in mode 1 still totals PROG_CYCLES.
- R9: A write of data 30h at any address while mode is 3 returns mode to 1. A 30h write in mode 1 has no effect, a B0h write in mode 0 has no effect, and a new suspend is accepted after a resume.
- R10: Status bit 6 flips after each status read (rd_en) in modes 1, 2, 4 and 5. It holds its value in modes 0 and 3.
- R11: Status bit 2 flips after each status read only in modes 4 and 5. It holds in all other modes.
- R12: Status bit 7 reads 0 during erase (modes 4 and 5). In modes 1, 2 and 3 it reads the inverse of bit 7 of the program data. In mode 0 it reads the true final value: 1 after an erase, the data's bit 7 after a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every write cycle and status read is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low hardware reset; aborts any operation |
| wr_en | input | 1 | Host write strobe, one write per cycle it is high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data (command byte or program data) |
| rd_en | input | 1 | Status read strobe; advances the toggle bits |
| status | output | 8 | Polling byte: bit 7 data polling, bit 6 toggle, bit 2 erase toggle, others 0 |
| mode | output | 3 | 0 read, 1 program, 2 suspend pending, 3 suspended, 4 erase preprogram, 5 erase |

## Verification
A decoder left in a half-unlocked state shows up only on the next write, where a sequence that should have been rejected starts an erase or a program, so the broken-sequence and erase-ignore scenarios each follow the bad step with the rest of a valid sequence. A counter that loses or gains a cycle across a suspend shows in the mode output as a total program time that differs from PROG_CYCLES; that difference is visible when the program completes, so the bench measures each phase length to the exact cycle. A toggle register that keeps running in the wrong mode appears on the second status read after the mode changes.

// File: rtl/nor_cmd_pkg.sv
// Shared types and command codes of the NOR command interpreter.
// Assumes byte-wide command data and unlock addresses that are compared in full.
package nor_cmd_pkg;

    // Operating modes; the encoding is visible on the mode port.
    typedef enum logic [2:0] {
        MODE_READ       = 3'd0,
        MODE_PROG       = 3'd1,
        MODE_SUSP_WAIT  = 3'd2,
        MODE_SUSPENDED  = 3'd3,
        MODE_ERASE_PRE  = 3'd4,
        MODE_ERASE_MAIN = 3'd5
    } mode_t;

    // Steps of the unlock/command decoder.
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_KEY1,
        SEQ_KEY2,
        SEQ_ERASE_ARMED,
        SEQ_KEY3,
        SEQ_KEY4,
        SEQ_PROG_ARMED
    } seq_t;

    localparam logic [11:0] KEY_ADDR_A = 12'h555;
    localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_ERASE_SETUP = 8'h80;
    localparam logic [7:0]  CMD_CHIP_ERASE  = 8'h10;
    localparam logic [7:0]  CMD_PROGRAM     = 8'hA0;
    localparam logic [7:0]  CMD_SUSPEND     = 8'hB0;
    localparam logic [7:0]  CMD_RESUME      = 8'h30;

endpackage

// File: rtl/nor_seq_decoder.sv
// Unlock-sequence decoder: follows host writes through the unlock steps and
// pulses start_erase or start_prog in the cycle of the final accepted write.
// Assumes accept is high only in read mode; otherwise the decoder stays idle.
module nor_seq_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              start_erase,
    output logic              start_prog
);

    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

    seq_t seq_q, seq_d;
    logic hit_a_key, hit_b_key;

    // Match the two unlock write patterns.
    always_comb begin
        hit_a_key = (wr_addr == ADDR_A) && (wr_data == KEY_DATA_A);
        hit_b_key = (wr_addr == ADDR_B) && (wr_data == KEY_DATA_B);
    end

    // Next-step decision; any mismatch falls back to idle.
    always_comb begin
        seq_d       = seq_q;
        start_erase = 1'b0;
        start_prog  = 1'b0;
        if (!accept) begin
            seq_d = SEQ_IDLE;
        end else if (wr_en) begin
            seq_d = SEQ_IDLE;
            case (seq_q)
                SEQ_IDLE:  if (hit_a_key) seq_d = SEQ_KEY1;
                SEQ_KEY1:  if (hit_b_key) seq_d = SEQ_KEY2;
                SEQ_KEY2: begin
                    if (wr_addr == ADDR_A && wr_data == CMD_ERASE_SETUP)
                        seq_d = SEQ_ERASE_ARMED;
                    else if (wr_addr == ADDR_A && wr_data == CMD_PROGRAM)
                        seq_d = SEQ_PROG_ARMED;
                end
                SEQ_ERASE_ARMED: if (hit_a_key) seq_d = SEQ_KEY3;
                SEQ_KEY3:  if (hit_b_key) seq_d = SEQ_KEY4;
                SEQ_KEY4:  start_erase = (wr_addr == ADDR_A) && (wr_data == CMD_CHIP_ERASE);
                SEQ_PROG_ARMED: start_prog = 1'b1;
                default:   seq_d = SEQ_IDLE;
            endcase
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_IDLE;
        else        seq_q <= seq_d;
    end

    // R5: while an operation owns the device the decoder holds no partial sequence.
    assert_decoder_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> seq_q == SEQ_IDLE);

    // R3: a start pulse only follows a step that was already armed.
    assert_start_needs_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_erase || start_prog) |-> seq_q != SEQ_IDLE);

endmodule

// File: rtl/nor_op_ctrl.sv
// Operation controller: holds the device mode, times the erase phases, the
// program and the suspend latency, and handles suspend/resume writes.
// Assumes every cycle parameter is at least 1; start pulses come only in read mode.
module nor_op_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int PROG_CYCLES  = 400,
    parameter int PREP_CYCLES  = 2000,
    parameter int ERASE_CYCLES = 6000,
    parameter int SUSP_CYCLES  = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       start_erase,
    input  logic       start_prog,
    output mode_t      mode
);

    localparam int MAX_AB  = (PREP_CYCLES > ERASE_CYCLES) ? PREP_CYCLES : ERASE_CYCLES;
    localparam int MAX_OP  = (MAX_AB > SUSP_CYCLES) ? MAX_AB : SUSP_CYCLES;
    localparam int OP_W    = $clog2(MAX_OP + 1);
    localparam int PROG_W  = $clog2(PROG_CYCLES + 1);

    localparam logic [OP_W-1:0]   PREP_LOAD  = OP_W'(PREP_CYCLES - 1);
    localparam logic [OP_W-1:0]   ERASE_LOAD = OP_W'(ERASE_CYCLES - 1);
    localparam logic [OP_W-1:0]   SUSP_LOAD  = OP_W'(SUSP_CYCLES - 1);
    localparam logic [PROG_W-1:0] PROG_LOAD  = PROG_W'(PROG_CYCLES - 1);

    mode_t             mode_q;
    logic [OP_W-1:0]   op_cnt;
    logic [PROG_W-1:0] prog_left;
    logic              sus_cmd, res_cmd;

    // Suspend and resume writes ignore the address.
    always_comb begin
        sus_cmd = wr_en && (wr_data == CMD_SUSPEND);
        res_cmd = wr_en && (wr_data == CMD_RESUME);
    end

    // Mode sequencing with phase and program countdowns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_READ;
            op_cnt    <= '0;
            prog_left <= '0;
        end else begin
            case (mode_q)
                MODE_READ: begin
                    if (start_erase) begin
                        mode_q <= MODE_ERASE_PRE;
                        op_cnt <= PREP_LOAD;
                    end else if (start_prog) begin
                        mode_q    <= MODE_PROG;
                        prog_left <= PROG_LOAD;
                    end
                end
                MODE_PROG: begin
                    if (prog_left == '0) begin
                        mode_q <= MODE_READ;
                    end else begin
                        prog_left <= prog_left - 1'b1;
                        if (sus_cmd) begin
                            mode_q <= MODE_SUSP_WAIT;
                            op_cnt <= SUSP_LOAD;
                        end
                    end
                end
                MODE_SUSP_WAIT: begin
                    if (op_cnt == '0) mode_q <= MODE_SUSPENDED;
                    else              op_cnt <= op_cnt - 1'b1;
                end
                MODE_SUSPENDED: begin
                    if (res_cmd) mode_q <= MODE_PROG;
                end
                MODE_ERASE_PRE: begin
                    if (op_cnt == '0) begin
                        mode_q <= MODE_ERASE_MAIN;
                        op_cnt <= ERASE_LOAD;
                    end else begin
                        op_cnt <= op_cnt - 1'b1;
                    end
                end
                MODE_ERASE_MAIN: begin
                    if (op_cnt == '0) mode_q <= MODE_READ;
                    else              op_cnt <= op_cnt - 1'b1;
                end
                default: mode_q <= MODE_READ;
            endcase
        end
    end

    assign mode = mode_q;

    // R6: hardware reset always lands in read mode.
    assert_reset_to_read_R6: assert property (@(posedge clk)
        !rst_n |=> mode_q == MODE_READ);

    // R4/R5: an erase only ever leaves to read mode.
    assert_erase_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ERASE_PRE || mode_q == MODE_ERASE_MAIN) |=>
        (mode_q == MODE_ERASE_PRE || mode_q == MODE_ERASE_MAIN || mode_q == MODE_READ));

    // R8: suspended mode is only reached through the suspend latency.
    assert_suspend_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_SUSPENDED |->
        ($past(mode_q) == MODE_SUSP_WAIT || $past(mode_q) == MODE_SUSPENDED));

    // R9: leaving suspended mode for program needs a resume write.
    assert_resume_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROG && $past(mode_q) == MODE_SUSPENDED) |->
        ($past(wr_en) && $past(wr_data) == CMD_RESUME));

    // R7: a program begins from read mode only on the decoder's start pulse.
    assert_prog_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROG && $past(mode_q) == MODE_READ) |-> $past(start_prog));

endmodule

// File: rtl/nor_status_gen.sv
// Status byte generator: data-polling bit, general toggle bit and erase toggle bit.
// Assumes start pulses arrive in read mode and rd_en marks one status read per cycle.
module nor_status_gen
    import nor_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mode_t      mode,
    input  logic       rd_en,
    input  logic       start_prog,
    input  logic       start_erase,
    input  logic [7:0] wr_data,
    output logic [7:0] status
);

    logic target_msb;
    logic tog_any, tog_erase;
    logic busy, erasing, prog_open;

    // Classify the current mode.
    always_comb begin
        erasing   = (mode == MODE_ERASE_PRE) || (mode == MODE_ERASE_MAIN);
        prog_open = (mode == MODE_PROG) || (mode == MODE_SUSP_WAIT) ||
                    (mode == MODE_SUSPENDED);
        busy      = erasing || (mode == MODE_PROG) || (mode == MODE_SUSP_WAIT);
    end

    // Remember bit 7 of the value the running operation will leave behind.
    always_ff @(posedge clk) begin
        if (!rst_n)           target_msb <= 1'b1;
        else if (start_erase) target_msb <= 1'b1;
        else if (start_prog)  target_msb <= wr_data[7];
    end

    // Toggle bits advance on each status read in their active modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_any   <= 1'b0;
            tog_erase <= 1'b0;
        end else if (rd_en) begin
            if (busy)    tog_any   <= ~tog_any;
            if (erasing) tog_erase <= ~tog_erase;
        end
    end

    // Assemble the polling byte.
    always_comb begin
        status    = 8'h00;
        status[6] = tog_any;
        status[2] = tog_erase;
        if (erasing)        status[7] = 1'b0;
        else if (prog_open) status[7] = ~target_msb;
        else                status[7] = target_msb;
    end

    // R10: the toggle bit is frozen without a read or outside busy modes.
    assert_toggle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || mode == MODE_READ || mode == MODE_SUSPENDED) |=> $stable(tog_any));

    // R11: the erase toggle bit is frozen outside erase.
    assert_erase_toggle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || !(mode == MODE_ERASE_PRE || mode == MODE_ERASE_MAIN)) |=>
        $stable(tog_erase));

    // R12: after an erase completes the polling bit shows the erased value.
    assert_erase_done_poll_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_ERASE_MAIN && mode == MODE_READ) |-> status[7]);

endmodule

// File: rtl/nor_cmd_seq.sv
// Top of the NOR command interpreter: decoder, operation controller and
// status generator. Assumes host writes and status reads are synchronous to clk.
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int PROG_CYCLES  = 400,
    parameter int PREP_CYCLES  = 2000,
    parameter int ERASE_CYCLES = 6000,
    parameter int SUSP_CYCLES  = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        status,
    output logic [2:0]        mode
);

    mode_t cur_mode;
    logic  go_erase, go_prog, in_read;

    // The decoder listens only in read mode.
    assign in_read = (cur_mode == MODE_READ);

    nor_seq_decoder #(.ADDR_W(ADDR_W)) u_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (in_read),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .start_erase (go_erase),
        .start_prog  (go_prog)
    );

    nor_op_ctrl #(
        .PROG_CYCLES  (PROG_CYCLES),
        .PREP_CYCLES  (PREP_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES),
        .SUSP_CYCLES  (SUSP_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .start_erase (go_erase),
        .start_prog  (go_prog),
        .mode        (cur_mode)
    );

    nor_status_gen u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (cur_mode),
        .rd_en       (rd_en),
        .start_prog  (go_prog),
        .start_erase (go_erase),
        .wr_data     (wr_data),
        .status      (status)
    );

    assign mode = cur_mode;

endmodule

// File: tb/test_nor_cmd_seq.sv
module test_nor_cmd_seq;

    localparam int AW = 24;
    localparam int P_PROG = 20, P_PREP = 30, P_ERASE = 40, P_SUSP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    status;
    logic [2:0]    mode;

    int n_chk = 0, n_fail = 0;
    int c_pre = 0, c_main = 0, c_prog = 0, c_swait = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .PROG_CYCLES(P_PROG), .PREP_CYCLES(P_PREP),
                  .ERASE_CYCLES(P_ERASE), .SUSP_CYCLES(P_SUSP)) i_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .status(status), .mode(mode));

    // Phase length counters, sampled mid-cycle from the mode port.
    always @(negedge clk) begin
        if (mode == 3'd4) c_pre++;
        if (mode == 3'd5) c_main++;
        if (mode == 3'd1) c_prog++;
        if (mode == 3'd2) c_swait++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        c_pre = 0; c_main = 0; c_prog = 0; c_swait = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        v = status;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_mode(input logic [2:0] m);
        for (int i = 0; i < 500 && mode != m; i++) @(negedge clk);
    endtask

    task automatic erase_seq();
        wr(24'h555, 8'hAA); wr(24'h2AA, 8'h55); wr(24'h555, 8'h80);
        wr(24'h555, 8'hAA); wr(24'h2AA, 8'h55); wr(24'h555, 8'h10);
    endtask

    task automatic prog_seq(input logic [7:0] d);
        wr(24'h555, 8'hAA); wr(24'h2AA, 8'h55); wr(24'h555, 8'hA0);
        wr(24'h01234, d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 mode after reset", mode, 0);
        chk("R1 status after reset", status, 8'h80);
    endtask

    task automatic t_bad_sequences();
        wr(24'h555, 8'hAB); wr(24'h2AA, 8'h55); wr(24'h555, 8'h80);
        wr(24'h555, 8'hAA); wr(24'h2AA, 8'h55); wr(24'h555, 8'h10);
        chk("R3 wrong first data", mode, 0);
        wr(24'h555, 8'hAA); wr(24'h2AA, 8'h55); wr(24'h555, 8'h80);
        wr(24'h555, 8'hAA); wr(24'h2AB, 8'h55); wr(24'h555, 8'h10);
        chk("R3 wrong fifth address", mode, 0);
        wr(24'h000, 8'hB0);
        chk("R9 suspend in read mode ignored", mode, 0);
    endtask

    task automatic t_erase_full();
        logic [7:0] s0, s1;
        clr();
        erase_seq();
        chk("R2 erase started", mode, 4);
        chk("R12 poll bit during erase", status[7], 0);
        rd(s0); rd(s1);
        chk("R11 erase toggle flips", s0[2] ^ s1[2], 1);
        chk("R10 toggle flips in erase", s0[6] ^ s1[6], 1);
        wait_mode(3'd0);
        @(negedge clk);
        chk("R4 preprogram length", c_pre, P_PREP);
        chk("R4 erase length", c_main, P_ERASE);
        chk("R12 poll bit after erase", status[7], 1);
        rd(s0); rd(s1);
        chk("R10 toggle holds in read mode", s0[6] ^ s1[6], 0);
    endtask

    task automatic t_erase_ignore();
        clr();
        erase_seq();
        wr(24'h000, 8'hB0); wr(24'h777, 8'h30);
        prog_seq(8'h12);
        erase_seq();
        chk("R5 still erasing after writes", (mode == 3'd4 || mode == 3'd5), 1);
        wait_mode(3'd0);
        @(negedge clk);
        chk("R5 preprogram length kept", c_pre, P_PREP);
        chk("R5 erase length kept", c_main, P_ERASE);
        chk("R5 no program started", c_prog + c_swait, 0);
    endtask

    task automatic t_reset_abort();
        erase_seq();
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 reset aborts erase", mode, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 stays in read after abort", mode, 0);
    endtask

    task automatic t_program();
        logic [7:0] s0, s1;
        clr();
        prog_seq(8'h35);
        chk("R7 program started", mode, 1);
        chk("R12 poll bit inverted in program", status[7], 1);
        rd(s0); rd(s1);
        chk("R10 toggle flips in program", s0[6] ^ s1[6], 1);
        chk("R11 erase toggle holds in program", s0[2] ^ s1[2], 0);
        wr(24'h100, 8'h30);
        chk("R9 resume in program ignored", mode, 1);
        wait_mode(3'd0);
        @(negedge clk);
        chk("R7 program length", c_prog, P_PROG);
        chk("R12 poll bit after program", status[7], 0);
    endtask

    task automatic t_suspend();
        logic [7:0] s0, s1;
        clr();
        prog_seq(8'hA5);
        repeat (3) @(negedge clk);
        wr(24'h00123, 8'hB0);
        chk("R8 suspend accepted", mode, 2);
        wait_mode(3'd3);
        chk("R8 suspended", mode, 3);
        chk("R8 suspend latency", c_swait, P_SUSP);
        chk("R12 poll bit while suspended", status[7], 0);
        rd(s0); rd(s1);
        chk("R10 toggle holds while suspended", s0[6] ^ s1[6], 0);
        wr(24'h0ABCD, 8'h30);
        chk("R9 resume accepted", mode, 1);
        wr(24'h00000, 8'h30);
        chk("R9 extra resume ignored", mode, 1);
        wr(24'h00456, 8'hB0);
        chk("R9 second suspend accepted", mode, 2);
        wait_mode(3'd3);
        wr(24'h00001, 8'h30);
        wait_mode(3'd0);
        @(negedge clk);
        chk("R8 program time kept over suspends", c_prog, P_PROG);
        chk("R12 poll bit after suspended program", status[7], 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bad_sequences();
        t_erase_full();
        t_erase_ignore();
        t_reset_abort();
        t_program();
        t_suspend();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule